// File: doc/BRIEF.md
# Two-level carry lookahead adder

A combinational binary adder that takes two operands and a carry-in and returns the sum together with the carry-out. It splits the operands into fixed 4-bit cells. Every bit forms a generate term (both operand bits set) and a propagate term (either operand bit set). From these, each cell derives a group generate and a group propagate. A second lookahead level turns the group terms and the carry-in into the carry entering each cell and the final carry-out. The sum bits use the exclusive-OR of the operand bits with the incoming carry. The propagate term is an inclusive OR, so it is never used in place of that half-sum.

The operand width is a parameter and must be a multiple of four. It defaults to 16, which gives four cells. A second parameter chooses how each cell forms its internal carries: a flat lookahead expression, or a bit-by-bit ripple chain. Either choice keeps lookahead at the cell boundaries, so both variants can be built side by side to compare carry paths while the arithmetic stays the same.

Top module: `cla_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_o, sum_o} equals a_i + b_i + c_i taken as unsigned numbers of WIDTH+1 bits.
- R2: With both operands zero and c_i = 0, sum_o is zero and carry_o is 0.
- R3: With both operands all ones and c_i = 1, sum_o is all ones and carry_o is 1.
- R4: With a_i all ones, b_i zero and c_i = 1, the carry-in passes through every cell. sum_o is zero and carry_o is 1.
- R5: With a_i all ones, b_i zero and c_i = 0, no carry arises. sum_o is all ones and carry_o is 0.
- R6: When both operands have only bit 4k+3 set (the top bit of cell k) and c_i = 0, the carry generated there reaches the next cell. sum_o has only bit 4k+4 set. For the last cell, sum_o is zero and carry_o is 1.
- R7: When both operands have only bit i set and c_i = 0, sum bit i is 0 and sum_o equals 2^(i+1) (wrapping into carry_o for the top bit). This shows the half-sum is an exclusive-OR and not the inclusive-OR propagate.
- R8: The ripple-inside-cell variant (MODE = CM_RIPPLE) gives the same sum_o and carry_o as the lookahead variant (MODE = CM_LOOKAHEAD) for every input.
- R9: With WIDTH = 8 (two cells), R1 holds for all 2^17 input combinations in both variants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
At each cell boundary, two sources of carry can be active together: a carry generated inside the cell below, and a carry propagated from further down through that cell. A correct boundary must give a single carry, and both sources must not double-count. The directed group-boundary task sets the top bit of one cell in both operands and sets the cell below to all-propagate with a carry-in. The exhaustive 8-bit sweep and the random 16-bit vectors then hit every mix of generate and propagate at both boundaries. Each outcome is judged against a plain arithmetic sum computed in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int CELL_W = 4;
  localparam int LA_MAX = 32;

  typedef enum logic {CM_LOOKAHEAD = 1'b0, CM_RIPPLE = 1'b1} carry_mode_e;

  // flat OR of generate terms over bits [0..n-1], each masked by higher propagates
  function automatic logic la_gen(input logic [LA_MAX-1:0] g,
                                  input logic [LA_MAX-1:0] p,
                                  input int n);
    logic r;
    logic t;
    r = 1'b0;
    for (int j = 0; j < LA_MAX; j++) begin
      t = g[j] && (j < n);
      for (int m = 0; m < LA_MAX; m++) begin
        if (m > j && m < n) t = t & p[m];
      end
      r = r | t;
    end
    return r;
  endfunction

  function automatic logic la_prop(input logic [LA_MAX-1:0] p, input int n);
    logic r;
    r = 1'b1;
    for (int m = 0; m < LA_MAX; m++) begin
      if (m < n) r = r & p[m];
    end
    return r;
  endfunction

endpackage

// File: rtl/cla_pg.sv
module cla_pg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o,
  output logic [W-1:0] h_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i | b_i;
  assign h_o = a_i ^ b_i;   // half-sum, kept apart from the OR propagate
endmodule

// File: rtl/cla_cell.sv
module cla_cell
  import cla_pkg::*;
#(
  parameter int          CW   = CELL_W,
  parameter carry_mode_e MODE = CM_LOOKAHEAD
) (
  input  logic [CW-1:0] a_i,
  input  logic [CW-1:0] b_i,
  input  logic          c_i,
  output logic [CW-1:0] sum_o,
  output logic          grp_g_o,
  output logic          grp_p_o
);
  logic [CW-1:0] g, p, h;
  logic [CW-1:0] c;

  cla_pg #(.W(CW)) u_pg (.a_i(a_i), .b_i(b_i), .g_o(g), .p_o(p), .h_o(h));

  if (MODE == CM_RIPPLE) begin : g_ripple
    always_comb begin
      c[0] = c_i;
      for (int i = 1; i < CW; i++) c[i] = g[i-1] | (p[i-1] & c[i-1]);
    end
  end else begin : g_la
    always_comb begin
      c[0] = c_i;
      for (int i = 1; i < CW; i++)
        c[i] = la_gen(LA_MAX'(g), LA_MAX'(p), i) | (la_prop(LA_MAX'(p), i) & c_i);
    end
  end

  assign grp_g_o = la_gen(LA_MAX'(g), LA_MAX'(p), CW);
  assign grp_p_o = la_prop(LA_MAX'(p), CW);
  assign sum_o   = h ^ c;
endmodule

// File: rtl/cla_unit.sv
module cla_unit
  import cla_pkg::*;
#(
  parameter int NGRP = 4
) (
  input  logic [NGRP-1:0] g_i,
  input  logic [NGRP-1:0] p_i,
  input  logic            c_i,
  output logic [NGRP:0]   c_o
);
  always_comb begin
    c_o[0] = c_i;
    for (int k = 1; k <= NGRP; k++)
      c_o[k] = la_gen(LA_MAX'(g_i), LA_MAX'(p_i), k) | (la_prop(LA_MAX'(p_i), k) & c_i);
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int          WIDTH = 16,
  parameter carry_mode_e MODE  = CM_LOOKAHEAD
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int NGRP = WIDTH / CELL_W;

  logic [NGRP-1:0] grp_g, grp_p;
  logic [NGRP:0]   bnd_c;

  for (genvar k = 0; k < NGRP; k++) begin : g_cell
    cla_cell #(.CW(CELL_W), .MODE(MODE)) u_cell (
      .a_i    (a_i[k*CELL_W +: CELL_W]),
      .b_i    (b_i[k*CELL_W +: CELL_W]),
      .c_i    (bnd_c[k]),
      .sum_o  (sum_o[k*CELL_W +: CELL_W]),
      .grp_g_o(grp_g[k]),
      .grp_p_o(grp_p[k])
    );
  end

  cla_unit #(.NGRP(NGRP)) u_unit (
    .g_i(grp_g),
    .p_i(grp_p),
    .c_i(c_i),
    .c_o(bnd_c)
  );

  assign carry_o = bnd_c[NGRP];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int WIDTH = 16,
  parameter int NGRP  = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             c_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic [NGRP-1:0]  grp_g,
  input logic [NGRP-1:0]  grp_p,
  input logic [NGRP:0]    bnd_c
);
  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      a_r1_arith: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(c_i)));
      a_r1_carry_out: assert (carry_o == bnd_c[NGRP]);
      for (int k = 0; k < NGRP; k++) begin
        a_r6_group_gen: assert (!grp_g[k] || bnd_c[k+1]);
        a_r4_group_prop: assert (!(grp_p[k] && bnd_c[k]) || bnd_c[k+1]);
        a_r5_group_kill: assert (grp_p[k] || grp_g[k] || !bnd_c[k+1]);
      end
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH), .NGRP(NGRP)) u_chk (
  .a_i(a_i), .b_i(b_i), .c_i(c_i), .sum_o(sum_o), .carry_o(carry_o),
  .grp_g(grp_g), .grp_p(grp_p), .bnd_c(bnd_c)
);

// File: tb/tb_cla_adder.sv
`timescale 1ns/1ps
module tb_cla_adder;
  import cla_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [15:0] a16, b16, s16, s16r;
  logic        cin, co16, co16r;
  logic [7:0]  a8, b8, s8, s8r;
  logic        cin8, co8, co8r;

  cla_adder #(.WIDTH(16), .MODE(CM_LOOKAHEAD)) dut (
    .a_i(a16), .b_i(b16), .c_i(cin), .sum_o(s16), .carry_o(co16));
  cla_adder #(.WIDTH(16), .MODE(CM_RIPPLE)) dut_rip (
    .a_i(a16), .b_i(b16), .c_i(cin), .sum_o(s16r), .carry_o(co16r));
  cla_adder #(.WIDTH(8), .MODE(CM_LOOKAHEAD)) dut8 (
    .a_i(a8), .b_i(b8), .c_i(cin8), .sum_o(s8), .carry_o(co8));
  cla_adder #(.WIDTH(8), .MODE(CM_RIPPLE)) dut8_rip (
    .a_i(a8), .b_i(b8), .c_i(cin8), .sum_o(s8r), .carry_o(co8r));

  task automatic chk(input string req, input logic [16:0] got, input logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive 16-bit inputs, check both variants against the requirement value and arithmetic
  task automatic apply16(input string req, input logic [15:0] a, input logic [15:0] b,
                         input logic c, input logic [16:0] exp);
    a16 = a; b16 = b; cin = c;
    #1;
    chk(req, {co16, s16}, exp);
    chk({req, "/R1"}, {co16, s16}, {1'b0, a} + {1'b0, b} + 17'(c));
    chk({req, "/R8"}, {co16r, s16r}, exp);
  endtask

  task automatic t_zero;
    apply16("R2", 16'h0000, 16'h0000, 1'b0, 17'h00000);
  endtask

  task automatic t_all_ones;
    apply16("R3", 16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF);
  endtask

  task automatic t_prop;
    apply16("R4", 16'hFFFF, 16'h0000, 1'b1, 17'h10000);
    apply16("R4", 16'h0000, 16'hFFFF, 1'b1, 17'h10000);
  endtask

  task automatic t_kill;
    apply16("R5", 16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF);
  endtask

  task automatic t_group_edges;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] v;
      v = 16'(1) << (4*k + 3);
      apply16("R6", v, v, 1'b0, 17'(1) << (4*k + 4));
      // generated carry and propagated carry meet at the same boundary
      apply16("R6", v | (v - 16'(1)), v, 1'b1, {1'b0, v | (v - 16'(1))} + {1'b0, v} + 17'd1);
    end
  endtask

  task automatic t_xor_halfsum;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] v;
      v = 16'(1) << i;
      apply16("R7", v, v, 1'b0, 17'(1) << (i + 1));
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a, b;
      logic c;
      a = 16'($urandom);
      b = 16'($urandom);
      c = 1'($urandom);
      apply16("R1", a, b, c, {1'b0, a} + {1'b0, b} + 17'(c));
    end
  endtask

  task automatic t_exhaustive8;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [8:0] exp;
          a8 = a[7:0]; b8 = b[7:0]; cin8 = c[0];
          exp = 9'(a) + 9'(b) + 9'(c);
          #1;
          chk("R9", 17'({co8, s8}), 17'(exp));
          chk("R9/R8", 17'({co8r, s8r}), 17'(exp));
        end
      end
    end
  endtask

  initial begin
    a16 = '0; b16 = '0; cin = 1'b0;
    a8 = '0; b8 = '0; cin8 = 1'b0;
    @(negedge clk);
    t_zero();
    t_all_ones();
    t_prop();
    t_kill();
    t_group_edges();
    t_xor_halfsum();
    t_random();
    t_exhaustive8();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule